// File: doc/BRIEF.md
# Dual-CPU Mailbox with Sync Nibble and Doorbell

This block couples two processors through a pair of one-way word queues and a small sync channel. Each processor sees an identical three-register window: a sync register, a control/status register and a FIFO data window. A word that one side writes to its data window is queued for the other side, which pops it by reading its own data window. Each side reads back the level of both queues, can flush its outgoing queue and enables two interrupts: one when its outgoing queue drains and one while its incoming queue holds data.

The sync register carries a 4-bit value from each side to the other, and lets either side ring a doorbell that reaches the peer as an interrupt when the peer has enabled it. Reads of an empty incoming queue and writes to a full outgoing queue set a sticky error flag that software clears by writing a one to it. A master enable per side gates all queue traffic from that side.

Accesses are single-cycle: a request with a write strobe takes effect at the next rising clock edge; read data is valid in the same cycle as the request, and a queue pop happens at the edge that ends the read.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty, every enable, the sync nibbles and the error flags are 0. The control register reads 0x0000_0101: bit 0 = outgoing queue empty, bit 8 = incoming queue empty. The sync register reads 0 and all interrupt outputs are low.
- R2: Sync bits 11:8 are read/write and hold the local nibble. The peer reads that nibble in its sync bits 3:0, which are read-only. Sync bit 14 is a read/write doorbell enable.
- R3: Writing 1 to sync bit 13 raises the peer's doorbell interrupt for exactly one cycle after the write edge, but only if the peer's sync bit 14 is set. Writing 0 to sync bit 13 does nothing, and bit 13 always reads 0.
- R4: Words written at offset 0x8 are read by the peer at offset 0x8 or 0xC in the order they were written.
- R5: Control bits 0/1 report outgoing queue empty/full, and bits 8/9 report incoming queue empty/full. A queue is full at 16 words.
- R6: Writing 1 to control bit 3 empties the outgoing queue. Bit 3 reads 0.
- R7: With the enable set, reading an empty incoming queue sets control bit 14, returns the last word popped (0 after reset) and leaves the queue unchanged.
- R8: With the enable set, writing to a full outgoing queue discards the word and sets control bit 14. Writing 1 to bit 14 clears the flag, and writing 0 leaves it set.
- R9: While control bit 15 is 0, data-window writes are dropped and reads do not pop: they return the last word popped. No error is flagged in either case.
- R10: With control bit 2 set, the outgoing-empty interrupt pulses for one cycle when the outgoing queue becomes empty.
- R11: With control bit 10 set, the incoming interrupt is high for as long as the incoming queue is not empty.
- R12: The two directions are independent. Words written by the second processor reach the first processor with the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_req_i | input | 1 | Side A access request |
| a_we_i | input | 1 | Side A write strobe |
| a_addr_i | input | 4 | Side A byte offset |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data |
| a_irq_bell_o | output | 1 | Side A doorbell interrupt |
| a_irq_tx_o | output | 1 | Side A outgoing-empty interrupt pulse |
| a_irq_rx_o | output | 1 | Side A incoming-not-empty interrupt |
| b_req_i | input | 1 | Side B access request |
| b_we_i | input | 1 | Side B write strobe |
| b_addr_i | input | 4 | Side B byte offset |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data |
| b_irq_bell_o | output | 1 | Side B doorbell interrupt |
| b_irq_tx_o | output | 1 | Side B outgoing-empty interrupt pulse |
| b_irq_rx_o | output | 1 | Side B incoming-not-empty interrupt |

## Verification
The assertions check on every cycle that:
- a doorbell interrupt is only raised one cycle after the peer rang;
- the peer nibble shows up in a sync read, and the write-only bits read 0;
- the incoming interrupt never stands over an empty queue;
- the outgoing-empty pulse lasts one cycle;
- an empty queue stays empty across a rejected read.

Only the directed scenarios can show the rest:
- word ordering through the queues;
- the full boundary at 16 words and the discarded 17th word;
- the error flag's set and acknowledge rules;
- flush;
- the behaviour with the enable cleared.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned NIB_W  = 4;

  localparam logic [REG_AW-1:0] OFF_SYNC = 4'h0;
  localparam logic [REG_AW-1:0] OFF_CTRL = 4'h4;
  localparam logic [REG_AW-1:0] OFF_DATA = 4'h8;
  localparam logic [REG_AW-1:0] OFF_RECV = 4'hC;

  // sync register fields
  localparam int unsigned SY_IN   = 0;
  localparam int unsigned SY_OUT  = 8;
  localparam int unsigned SY_BELL = 13;
  localparam int unsigned SY_IEN  = 14;

  // control register fields
  localparam int unsigned CT_TX_EMPTY = 0;
  localparam int unsigned CT_TX_FULL  = 1;
  localparam int unsigned CT_TX_IEN   = 2;
  localparam int unsigned CT_TX_FLUSH = 3;
  localparam int unsigned CT_RX_EMPTY = 8;
  localparam int unsigned CT_RX_FULL  = 9;
  localparam int unsigned CT_RX_IEN   = 10;
  localparam int unsigned CT_ERR      = 14;
  localparam int unsigned CT_EN       = 15;
endpackage

// File: rtl/ipc_fifo.sv
// DEPTH must be a power of two.
module ipc_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  input  logic         flush_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW:0]  wr_q, rd_q;
  logic [W-1:0] mem_q [DEPTH];
  logic         do_push, do_pop;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q[AW-1:0]] <= data_i;
  end
endmodule

// File: rtl/ipc_port.sv
module ipc_port
  import ipc_mailbox_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  // outgoing queue
  output logic              tx_push_o,
  output logic              tx_flush_o,
  input  logic              tx_empty_i,
  input  logic              tx_full_i,
  // incoming queue
  output logic              rx_pop_o,
  input  logic [W-1:0]      rx_head_i,
  input  logic              rx_empty_i,
  input  logic              rx_full_i,
  // sync channel
  output logic [NIB_W-1:0]  nib_o,
  input  logic [NIB_W-1:0]  nib_i,
  output logic              bell_o,
  input  logic              bell_i,
  // interrupts
  output logic              irq_bell_o,
  output logic              irq_tx_o,
  output logic              irq_rx_o
);
  logic wr, rd, hit_sync, hit_ctrl, hit_tx, hit_rx;
  logic err_set, err_clr;
  logic [NIB_W-1:0] nib_q;
  logic sy_ien_q, tx_ien_q, rx_ien_q, en_q, err_q, bell_irq_q, tx_empty_q;
  logic [W-1:0] last_q;

  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign hit_sync = (addr_i == OFF_SYNC);
  assign hit_ctrl = (addr_i == OFF_CTRL);
  assign hit_tx   = (addr_i == OFF_DATA);
  assign hit_rx   = (addr_i == OFF_DATA) || (addr_i == OFF_RECV);

  assign tx_push_o  = wr && hit_tx && en_q && !tx_full_i;
  assign rx_pop_o   = rd && hit_rx && en_q && !rx_empty_i;
  assign tx_flush_o = wr && hit_ctrl && wdata_i[CT_TX_FLUSH];
  assign bell_o     = wr && hit_sync && wdata_i[SY_BELL];
  assign err_set    = en_q && ((wr && hit_tx && tx_full_i) || (rd && hit_rx && rx_empty_i));
  assign err_clr    = wr && hit_ctrl && wdata_i[CT_ERR];
  assign nib_o      = nib_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nib_q      <= '0;
      sy_ien_q   <= 1'b0;
      tx_ien_q   <= 1'b0;
      rx_ien_q   <= 1'b0;
      en_q       <= 1'b0;
      err_q      <= 1'b0;
      bell_irq_q <= 1'b0;
      tx_empty_q <= 1'b1;
      last_q     <= '0;
    end else begin
      if (wr && hit_sync) begin
        nib_q    <= wdata_i[SY_OUT +: NIB_W];
        sy_ien_q <= wdata_i[SY_IEN];
      end
      if (wr && hit_ctrl) begin
        tx_ien_q <= wdata_i[CT_TX_IEN];
        rx_ien_q <= wdata_i[CT_RX_IEN];
        en_q     <= wdata_i[CT_EN];
      end
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (rx_pop_o) last_q <= rx_head_i;
      bell_irq_q <= bell_i && sy_ien_q;
      tx_empty_q <= tx_empty_i;
    end
  end

  assign irq_bell_o = bell_irq_q;
  assign irq_tx_o   = tx_ien_q && tx_empty_i && !tx_empty_q;
  assign irq_rx_o   = rx_ien_q && !rx_empty_i;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_SYNC: begin
        rdata_o[SY_IN +: NIB_W]  = nib_i;
        rdata_o[SY_OUT +: NIB_W] = nib_q;
        rdata_o[SY_IEN]          = sy_ien_q;
      end
      OFF_CTRL: begin
        rdata_o[CT_TX_EMPTY] = tx_empty_i;
        rdata_o[CT_TX_FULL]  = tx_full_i;
        rdata_o[CT_TX_IEN]   = tx_ien_q;
        rdata_o[CT_RX_EMPTY] = rx_empty_i;
        rdata_o[CT_RX_FULL]  = rx_full_i;
        rdata_o[CT_RX_IEN]   = rx_ien_q;
        rdata_o[CT_ERR]      = err_q;
        rdata_o[CT_EN]       = en_q;
      end
      OFF_DATA, OFF_RECV: rdata_o = rx_pop_o ? rx_head_i : last_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_req_i,
  input  logic              a_we_i,
  input  logic [REG_AW-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_irq_bell_o,
  output logic              a_irq_tx_o,
  output logic              a_irq_rx_o,
  input  logic              b_req_i,
  input  logic              b_we_i,
  input  logic [REG_AW-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_irq_bell_o,
  output logic              b_irq_tx_o,
  output logic              b_irq_rx_o
);
  localparam int unsigned NSIDE = 2;

  // queue q carries words from side q to side 1-q
  logic [NSIDE-1:0]             req, we, push, pop, flush, fifo_empty, fifo_full, bell;
  logic [NSIDE-1:0]             irq_bell, irq_tx, irq_rx;
  logic [NSIDE-1:0][REG_AW-1:0] addr;
  logic [NSIDE-1:0][DATA_W-1:0] wdata, rdata, head;
  logic [NSIDE-1:0][NIB_W-1:0]  nib;

  assign req   = {b_req_i, a_req_i};
  assign we    = {b_we_i, a_we_i};
  assign addr  = {b_addr_i, a_addr_i};
  assign wdata = {b_wdata_i, a_wdata_i};

  assign a_rdata_o    = rdata[0];
  assign b_rdata_o    = rdata[1];
  assign a_irq_bell_o = irq_bell[0];
  assign b_irq_bell_o = irq_bell[1];
  assign a_irq_tx_o   = irq_tx[0];
  assign b_irq_tx_o   = irq_tx[1];
  assign a_irq_rx_o   = irq_rx[0];
  assign b_irq_rx_o   = irq_rx[1];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    ipc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[s]),
      .data_i  (wdata[s]),
      .pop_i   (pop[1-s]),
      .flush_i (flush[s]),
      .head_o  (head[s]),
      .empty_o (fifo_empty[s]),
      .full_o  (fifo_full[s])
    );

    ipc_port #(.W(DATA_W)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req[s]),
      .we_i       (we[s]),
      .addr_i     (addr[s]),
      .wdata_i    (wdata[s]),
      .rdata_o    (rdata[s]),
      .tx_push_o  (push[s]),
      .tx_flush_o (flush[s]),
      .tx_empty_i (fifo_empty[s]),
      .tx_full_i  (fifo_full[s]),
      .rx_pop_o   (pop[s]),
      .rx_head_i  (head[1-s]),
      .rx_empty_i (fifo_empty[1-s]),
      .rx_full_i  (fifo_full[1-s]),
      .nib_o      (nib[s]),
      .nib_i      (nib[1-s]),
      .bell_o     (bell[s]),
      .bell_i     (bell[1-s]),
      .irq_bell_o (irq_bell[s]),
      .irq_tx_o   (irq_tx[s]),
      .irq_rx_o   (irq_rx[s])
    );
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
  import ipc_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             req,
  input logic [1:0]             we,
  input logic [1:0][REG_AW-1:0] addr,
  input logic [1:0][DATA_W-1:0] rdata,
  input logic [1:0]             fifo_empty,
  input logic [1:0]             fifo_full,
  input logic [1:0]             bell,
  input logic [1:0][NIB_W-1:0]  nib,
  input logic [1:0]             irq_bell,
  input logic [1:0]             irq_tx,
  input logic [1:0]             irq_rx
);
  for (genvar s = 0; s < 2; s++) begin : g_chk
    assert_sync_cross_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req[s] && !we[s] && addr[s] == OFF_SYNC) |-> (rdata[s][SY_IN +: NIB_W] == nib[1-s]));

    assert_bell_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req[s] && !we[s] && addr[s] == OFF_SYNC) |-> !rdata[s][SY_BELL]);

    assert_bell_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_bell[s] |-> $past(bell[1-s]));

    assert_fill_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_empty[s] |=> !fifo_full[s]);

    assert_flush_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req[s] && !we[s] && addr[s] == OFF_CTRL) |-> !rdata[s][CT_TX_FLUSH]);

    assert_empty_read_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req[s] && !we[s] && (addr[s] == OFF_DATA || addr[s] == OFF_RECV) && fifo_empty[1-s]
       && !(req[1-s] && we[1-s] && addr[1-s] == OFF_DATA)) |=> fifo_empty[1-s]);

    assert_tx_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_tx[s] |=> !irq_tx[s]);

    assert_tx_on_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_tx[s] |-> fifo_empty[s]);

    assert_rx_level_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_rx[s] |-> !fifo_empty[1-s]);
  end
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req        (req),
  .we         (we),
  .addr       (addr),
  .rdata      (rdata),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .bell       (bell),
  .nib        (nib),
  .irq_bell   (irq_bell),
  .irq_tx     (irq_tx),
  .irq_rx     (irq_rx)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] req = '0, we = '0;
  logic [3:0] addr [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic [1:0] irq_bell, irq_tx, irq_rx;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ipc_mailbox u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_req_i(req[0]), .a_we_i(we[0]), .a_addr_i(addr[0]), .a_wdata_i(wdata[0]),
    .a_rdata_o(rdata[0]), .a_irq_bell_o(irq_bell[0]), .a_irq_tx_o(irq_tx[0]), .a_irq_rx_o(irq_rx[0]),
    .b_req_i(req[1]), .b_we_i(we[1]), .b_addr_i(addr[1]), .b_wdata_i(wdata[1]),
    .b_rdata_o(rdata[1]), .b_irq_bell_o(irq_bell[1]), .b_irq_tx_o(irq_tx[1]), .b_irq_rx_o(irq_rx[1])
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic acc(input int p, input logic w, input logic [3:0] ad,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    req[p] = 1'b1; we[p] = w; addr[p] = ad; wdata[p] = d;
    #1 q = rdata[p];
    @(posedge clk);
    #1 req[p] = 1'b0; we[p] = 1'b0;
  endtask

  task automatic wr(input int p, input logic [3:0] ad, input logic [31:0] d);
    logic [31:0] q;
    acc(p, 1'b1, ad, d, q);
  endtask

  task automatic rd_chk(input int p, input logic [3:0] ad, input string tag, input logic [31:0] exp);
    logic [31:0] q;
    acc(p, 1'b0, ad, 32'h0, q);
    check(tag, q, exp);
  endtask

  task automatic do_reset();
    req = '0; we = '0;
    addr[0] = '0; addr[1] = '0; wdata[0] = '0; wdata[1] = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk(0, 4'h4, "R1 ctrl A", 32'h0101);
    rd_chk(1, 4'h4, "R1 ctrl B", 32'h0101);
    rd_chk(0, 4'h0, "R1 sync A", 32'h0);
    rd_chk(1, 4'h0, "R1 sync B", 32'h0);
    check("R1 irqs", {26'h0, irq_bell, irq_tx, irq_rx}, 32'h0);
  endtask

  task automatic t_sync();
    do_reset();
    wr(0, 4'h0, 32'h0A00);
    rd_chk(0, 4'h0, "R2 own nibble A", 32'h0A00);
    rd_chk(1, 4'h0, "R2 remote nibble at B", 32'h000A);
    wr(1, 4'h0, 32'h4300);
    rd_chk(1, 4'h0, "R2 B nibble+ien", 32'h430A);
    rd_chk(0, 4'h0, "R2 remote nibble at A", 32'h0A03);
    wr(0, 4'h0, 32'h000F);  // bits 3:0 read-only
    rd_chk(0, 4'h0, "R2 input nibble read-only", 32'h0003);
  endtask

  task automatic t_bell();
    do_reset();
    wr(1, 4'h0, 32'h4000);
    check("R3 no bell before ring", {31'h0, irq_bell[1]}, 32'h0);
    wr(0, 4'h0, 32'h2500);
    check("R3 bell pulse", {31'h0, irq_bell[1]}, 32'h1);
    @(posedge clk); #1;
    check("R3 bell one cycle", {31'h0, irq_bell[1]}, 32'h0);
    rd_chk(0, 4'h0, "R3 bell bit reads 0", 32'h0500);
    wr(0, 4'h0, 32'h0500);
    check("R3 writing 0 no bell", {31'h0, irq_bell[1]}, 32'h0);
    wr(1, 4'h0, 32'h0000);
    wr(0, 4'h0, 32'h2000);
    check("R3 masked bell", {31'h0, irq_bell[1]}, 32'h0);
    check("R3 sender not rung", {31'h0, irq_bell[0]}, 32'h0);
  endtask

  task automatic t_order();
    do_reset();
    wr(0, 4'h4, 32'h8000);
    wr(1, 4'h4, 32'h8000);
    wr(0, 4'h8, 32'hA1);
    wr(0, 4'h8, 32'hA2);
    wr(0, 4'h8, 32'hA3);
    rd_chk(1, 4'h8, "R4 first word", 32'hA1);
    rd_chk(1, 4'hC, "R4 second word alt offset", 32'hA2);
    rd_chk(1, 4'h8, "R4 third word", 32'hA3);
    wr(1, 4'h8, 32'hB1);
    wr(1, 4'h8, 32'hB2);
    rd_chk(0, 4'h4, "R12 A sees incoming", 32'h8001);
    rd_chk(0, 4'hC, "R12 reverse first", 32'hB1);
    rd_chk(0, 4'h8, "R12 reverse second", 32'hB2);
  endtask

  task automatic t_full();
    do_reset();
    wr(0, 4'h4, 32'h8000);
    wr(1, 4'h4, 32'h8000);
    for (int i = 0; i < 16; i++) wr(0, 4'h8, 32'h100 + i);
    rd_chk(0, 4'h4, "R5 A send full", 32'h8102);
    rd_chk(1, 4'h4, "R5 B recv full", 32'h8201);
    wr(0, 4'h8, 32'hDEAD);
    rd_chk(0, 4'h4, "R8 error on full write", 32'hC102);
    wr(0, 4'h4, 32'h8000);
    rd_chk(0, 4'h4, "R8 write 0 keeps error", 32'hC102);
    wr(0, 4'h4, 32'hC000);
    rd_chk(0, 4'h4, "R8 write 1 clears error", 32'h8102);
    for (int i = 0; i < 16; i++) rd_chk(1, 4'h8, "R8 order, 17th discarded", 32'h100 + i);
    rd_chk(1, 4'h4, "R5 B empty after drain", 32'h8101);
  endtask

  task automatic t_empty_read();
    do_reset();
    wr(0, 4'h4, 32'h8000);
    wr(1, 4'h4, 32'h8000);
    rd_chk(1, 4'h8, "R7 empty read after reset", 32'h0);
    wr(0, 4'h8, 32'h55);
    rd_chk(1, 4'h8, "R7 normal read", 32'h55);
    rd_chk(1, 4'h8, "R7 empty read returns last", 32'h55);
    rd_chk(1, 4'h4, "R7 error set", 32'hC101);
    wr(1, 4'h4, 32'hC000);
    wr(0, 4'h8, 32'h66);
    rd_chk(1, 4'h8, "R7 queue intact after empty read", 32'h66);
    rd_chk(1, 4'h4, "R7 error cleared", 32'h8101);
  endtask

  task automatic t_flush();
    do_reset();
    wr(0, 4'h4, 32'h8000);
    wr(1, 4'h4, 32'h8000);
    wr(0, 4'h8, 32'h1);
    wr(0, 4'h8, 32'h2);
    wr(0, 4'h8, 32'h3);
    wr(0, 4'h4, 32'h8008);
    rd_chk(1, 4'h4, "R6 receiver empty after flush", 32'h8101);
    rd_chk(0, 4'h4, "R6 flush bit reads 0", 32'h8101);
    wr(0, 4'h8, 32'h77);
    rd_chk(1, 4'h8, "R6 queue usable after flush", 32'h77);
  endtask

  task automatic t_disable();
    do_reset();
    wr(1, 4'h4, 32'h8000);
    wr(0, 4'h8, 32'h11);
    rd_chk(1, 4'h4, "R9 disabled write dropped", 32'h8101);
    rd_chk(0, 4'h4, "R9 no error on disabled write", 32'h0101);
    wr(0, 4'h4, 32'h8000);
    wr(0, 4'h8, 32'h22);
    wr(1, 4'h4, 32'h0000);
    rd_chk(1, 4'h8, "R9 disabled read returns last", 32'h0);
    rd_chk(1, 4'h4, "R9 disabled read no pop no error", 32'h0001);
    wr(1, 4'h4, 32'h8000);
    rd_chk(1, 4'h8, "R9 word kept", 32'h22);
  endtask

  task automatic t_irq_tx();
    do_reset();
    wr(0, 4'h4, 32'h8004);
    wr(1, 4'h4, 32'h8000);
    check("R10 no pulse while idle empty", {31'h0, irq_tx[0]}, 32'h0);
    wr(0, 4'h8, 32'h5);
    wr(0, 4'h8, 32'h6);
    rd_chk(1, 4'h8, "R10 pop 1", 32'h5);
    check("R10 no pulse while not empty", {31'h0, irq_tx[0]}, 32'h0);
    rd_chk(1, 4'h8, "R10 pop 2", 32'h6);
    check("R10 pulse on drain", {31'h0, irq_tx[0]}, 32'h1);
    @(posedge clk); #1;
    check("R10 pulse one cycle", {31'h0, irq_tx[0]}, 32'h0);
  endtask

  task automatic t_irq_rx();
    do_reset();
    wr(0, 4'h4, 32'h8000);
    wr(1, 4'h4, 32'h8400);
    check("R11 low while empty", {31'h0, irq_rx[1]}, 32'h0);
    wr(0, 4'h8, 32'h9);
    check("R11 high on data", {31'h0, irq_rx[1]}, 32'h1);
    repeat (3) @(posedge clk);
    #1 check("R11 level holds", {31'h0, irq_rx[1]}, 32'h1);
    wr(1, 4'h4, 32'h8000);
    check("R11 masked", {31'h0, irq_rx[1]}, 32'h0);
    wr(1, 4'h4, 32'h8400);
    check("R11 unmasked", {31'h0, irq_rx[1]}, 32'h1);
    rd_chk(1, 4'h8, "R11 pop", 32'h9);
    check("R11 low after drain", {31'h0, irq_rx[1]}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sync();
    t_bell();
    t_order();
    t_full();
    t_empty_read();
    t_flush();
    t_disable();
    t_irq_tx();
    t_irq_rx();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule